// File: doc/BRIEF.md
# Management Frame Master for PHY Register Access

This block reads and writes registers in an Ethernet PHY over the two-wire management interface, a clock (MDC) and a bidirectional data line (MDIO). Software loads one 32-bit command word whose bits are exactly the bits that go onto the wire after the preamble. That write alone launches the transaction. The block first sends a run of preamble ones and then the 32 command bits, most significant first. On a read, it lets go of the data line from the turnaround onward and collects the 16 bits the PHY sends back.

When the last bit has gone out, an event flag is raised. After a read, the low half of the command/data register holds the value returned by the PHY. The MDC rate comes from a speed register: MDC spends `speed` system clocks high and `speed` system clocks low. Software typically loads twice the rounded-up ratio of the system clock to 5 MHz, which keeps MDC at or below 2.5 MHz.

The flags in the event register are cleared by writing ones to them. A command written while another is still pending or in flight is dropped, and a sticky overrun flag records that this happened.

Top module: `mdioMaster`

## Requirements
- R1: After reset MDC is low, the MDIO output enable is low, MDIO out is high, and the command register (address 0), the speed register (address 1) and the event register (address 2) all read as zero.
- R2: Each transaction puts on MDIO, sampled at each MDC rising edge, 32 preamble slots of 1, then bits 31 down to 0 of the command word. Bits 31:30 are the start pattern 01, bits 29:28 the opcode (10 read, 01 write), bits 27:23 the PHY address, bits 22:18 the register number, bits 17:16 the turnaround and bits 15:0 the write data.
- R3: While a frame runs, successive MDC rising edges are exactly 2×speed system clocks apart, for any nonzero speed including 1.
- R4: For a read (opcode 10), the output enable is low during the two turnaround slots and the 16 data slots. MDIO is sampled at the MDC rising edges of the data slots, most significant bit first. After completion, bits 15:0 of register 0 hold the sampled value and bits 31:16 keep the command.
- R5: A read from an address where no PHY answers returns 0xFFFF, because MDIO idles high.
- R6: Bit 23 of the event register is 0 while a frame runs and becomes 1 once the last slot finishes.
- R7: Writing the event register clears each flag whose bit is written as 1. Flags whose bit is written as 0 keep their value.
- R8: While speed is 0, MDC stays still. A command written then is held and starts only once a nonzero speed is programmed.
- R9: A command written while a command is pending or in flight is ignored: register 0 and the frame on the wire are unchanged. Event bit 0 (overrun) becomes 1 and stays 1 until it is cleared by writing 1 to it.
- R10: For a write (opcode 01), the output enable stays high through all 64 slots, so the master drives the turnaround and data bits itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 command/data, 1 speed, 2 event |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value from the pad |

## Verification
The hardest situations to reach from the ports are the ones where a command write lands on a busy engine: a second command during a live frame, and a command parked behind a zero speed. The stimulus programs speed 0, writes a command and lets many cycles pass before a nonzero speed releases it. Separately, it injects a second command midway through a read and then shows that both the wire frame and the returned data belong to the first command. A PHY model in the bench answers only at one address and changes MDIO on MDC falling edges, so the release window and the sampling edge are both tested against a real turnaround.

// File: rtl/mdioMasterPkg.sv
package mdioMasterPkg;
  localparam int CMD_W       = 32;
  localparam int RES_W       = 16;
  localparam int EVT_DONE    = 23;
  localparam int EVT_OVERRUN = 0;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] ADDR_CMD   = 2'd0;
  localparam logic [1:0] ADDR_SPEED = 2'd1;
  localparam logic [1:0] ADDR_EVT   = 2'd2;
  // Offsets of frame fields after the preamble
  localparam int TA_OFFSET   = 14;
  localparam int DATA_OFFSET = 16;

  typedef struct packed {
    logic start;
    logic isRead;
  } ctrlStrobe_t;

  typedef struct packed {
    logic busy;
    logic done;
  } dpStatus_t;
endpackage

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdioMasterPkg::*;
#(
  parameter int SPEED_W      = 8,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [CMD_W-1:0]     cmdWord,
  input  logic [SPEED_W-1:0]   speed,
  input  logic                 mdioIn,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic                 mdioOe,
  output dpStatus_t            status,
  output logic [RES_W-1:0]     rdResult
);
  localparam int TOTAL_SLOTS = PREAMBLE_LEN + CMD_W;
  localparam int IDX_W       = $clog2(TOTAL_SLOTS);
  localparam int TA_SLOT     = PREAMBLE_LEN + TA_OFFSET;
  localparam int DATA_SLOT   = PREAMBLE_LEN + DATA_OFFSET;

  logic [IDX_W-1:0]   slot;
  logic [SPEED_W-1:0] divCnt;
  logic               busy;
  logic               done;
  logic               isReadQ;
  logic               tick;
  logic               speedOk;

  function automatic logic bitAt(input int s, input logic [CMD_W-1:0] c);
    if (s < PREAMBLE_LEN) return 1'b1;
    return c[CMD_W-1-(s-PREAMBLE_LEN)];
  endfunction

  function automatic logic releasedAt(input int s, input logic rd);
    return rd && (s >= TA_SLOT);
  endfunction

  assign speedOk = (speed != '0);
  assign tick    = busy && speedOk &&
                   (({1'b0, divCnt} + (SPEED_W+1)'(1)) >= {1'b0, speed});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      mdc      <= 1'b0;
      mdioOut  <= 1'b1;
      mdioOe   <= 1'b0;
      slot     <= '0;
      divCnt   <= '0;
      isReadQ  <= 1'b0;
      rdResult <= '0;
    end else begin
      done <= 1'b0;
      if (strobe.start) begin
        busy    <= 1'b1;
        mdc     <= 1'b0;
        slot    <= '0;
        divCnt  <= '0;
        isReadQ <= strobe.isRead;
        mdioOut <= 1'b1;
        mdioOe  <= 1'b1;
      end else if (busy && speedOk) begin
        if (tick) begin
          divCnt <= '0;
          if (!mdc) begin
            // rising edge: sample returned data
            mdc <= 1'b1;
            if (isReadQ && int'(slot) >= DATA_SLOT)
              rdResult <= {rdResult[RES_W-2:0], mdioIn};
          end else begin
            // falling edge: move to the next slot
            mdc <= 1'b0;
            if (int'(slot) == TOTAL_SLOTS-1) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              mdioOe  <= 1'b0;
              mdioOut <= 1'b1;
            end else begin
              slot    <= slot + IDX_W'(1);
              mdioOut <= bitAt(int'(slot)+1, cmdWord);
              mdioOe  <= !releasedAt(int'(slot)+1, isReadQ);
            end
          end
        end else begin
          divCnt <= divCnt + SPEED_W'(1);
        end
      end
    end
  end

  assign status.busy = busy;
  assign status.done = done;

  a_r8_zero_speed_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (busy && speed == '0 && !strobe.start) |=> ($stable(mdc) && $stable(slot)));
  a_r4_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isReadQ && int'(slot) >= TA_SLOT) |-> !mdioOe);
  a_r2_preamble_high: assert property (@(posedge clk) disable iff (!rstN)
    (busy && int'(slot) < PREAMBLE_LEN) |-> (mdioOut && mdioOe));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));
  a_r10_write_drives: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isReadQ) |-> mdioOe);
endmodule

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioMasterPkg::*;
#(
  parameter int SPEED_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [CMD_W-1:0]   regWrData,
  output logic [CMD_W-1:0]   regRdData,
  output logic [SPEED_W-1:0] speed,
  output logic [CMD_W-1:0]   cmdWord,
  output ctrlStrobe_t        strobe,
  input  dpStatus_t          status,
  input  logic [RES_W-1:0]   rdResult
);
  logic [CMD_W-1:0]   cmdReg;
  logic [SPEED_W-1:0] speedReg;
  logic               evtDone;
  logic               evtOverrun;
  logic               pending;
  logic               wrCmd;
  logic               wrSpeed;
  logic               wrEvt;
  logic               blocked;
  logic               cmdIsRead;

  assign wrCmd     = regWrEn && regAddr == ADDR_CMD;
  assign wrSpeed   = regWrEn && regAddr == ADDR_SPEED;
  assign wrEvt     = regWrEn && regAddr == ADDR_EVT;
  assign blocked   = pending || status.busy;
  assign cmdIsRead = (cmdReg[CMD_W-3:CMD_W-4] == OP_READ);

  assign strobe.start  = pending && (speedReg != '0) && !status.busy;
  assign strobe.isRead = cmdIsRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg     <= '0;
      speedReg   <= '0;
      evtDone    <= 1'b0;
      evtOverrun <= 1'b0;
      pending    <= 1'b0;
    end else begin
      if (strobe.start) pending <= 1'b0;
      if (wrCmd) begin
        if (!blocked) begin
          cmdReg  <= regWrData;
          pending <= 1'b1;
        end
      end
      if (wrSpeed) speedReg <= regWrData[SPEED_W-1:0];
      if (wrEvt && regWrData[EVT_DONE])    evtDone    <= 1'b0;
      if (wrEvt && regWrData[EVT_OVERRUN]) evtOverrun <= 1'b0;
      if (status.done) begin
        evtDone <= 1'b1;
        if (cmdIsRead) cmdReg[RES_W-1:0] <= rdResult;
      end
      if (wrCmd && blocked) evtOverrun <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CMD:   regRdData = cmdReg;
      ADDR_SPEED: regRdData[SPEED_W-1:0] = speedReg;
      ADDR_EVT: begin
        regRdData[EVT_DONE]    = evtDone;
        regRdData[EVT_OVERRUN] = evtOverrun;
      end
      default:    regRdData = '0;
    endcase
  end

  assign speed   = speedReg;
  assign cmdWord = cmdReg;

  a_r6_done_raises_event: assert property (@(posedge clk) disable iff (!rstN)
    status.done |=> evtDone);
  a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && blocked && !status.done) |=> (evtOverrun && $stable(cmdReg)));
  a_r7_zero_keeps_done: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvt && !regWrData[EVT_DONE] && evtDone) |=> evtDone);
  a_r8_no_start_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (speedReg == '0) |-> !strobe.start);
endmodule

// File: rtl/mdioMaster.sv
module mdioMaster
  import mdioMasterPkg::*;
#(
  parameter int SPEED_W      = 8,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  ctrlStrobe_t        strobe;
  dpStatus_t          status;
  logic [SPEED_W-1:0] speed;
  logic [CMD_W-1:0]   cmdWord;
  logic [RES_W-1:0]   rdResult;

  mdioCtrl #(.SPEED_W(SPEED_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .speed(speed),
    .cmdWord(cmdWord), .strobe(strobe), .status(status), .rdResult(rdResult)
  );

  mdioDatapath #(.SPEED_W(SPEED_W), .PREAMBLE_LEN(PREAMBLE_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWord(cmdWord), .speed(speed),
    .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .status(status), .rdResult(rdResult)
  );
endmodule

// File: tb/test_mdioMaster.sv
module test_mdioMaster;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  mdioMaster i_mdioMaster (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [63:0] outBits;
    logic [63:0] oeBits;
    string       req;
  } expFrame_t;

  expFrame_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int curSpeed = 0;
  int lastRise = 0;
  int riseCnt = 0;
  int periodBad = 0;
  int framesSeen = 0;
  logic [63:0] capOut = '0;
  logic [63:0] capOe = '0;
  localparam logic [4:0] PHY_ADDR = 5'd3;

  function automatic logic [15:0] phyVal(input logic [4:0] r);
    return 16'hA5C0 ^ (16'h0111 * {11'd0, r});
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) cyc++;

  // Scoreboard monitor: collect each slot at MDC rising edge
  always @(posedge mdc) begin
    if (riseCnt > 0 && (cyc - lastRise) != 2*curSpeed) periodBad++;
    lastRise = cyc;
    capOut[riseCnt] = mdioOut;
    capOe[riseCnt]  = mdioOe;
    riseCnt++;
    if (riseCnt == 64) begin
      riseCnt = 0;
      framesSeen++;
      if (expQ.size() == 0) begin
        chk("R2 unexpected frame", 32'd1, 32'd0);
      end else begin
        expFrame_t e;
        e = expQ.pop_front();
        chk({e.req, " oe hi"}, capOe[63:32], e.oeBits[63:32]);
        chk({e.req, " oe lo"}, capOe[31:0], e.oeBits[31:0]);
        chk({e.req, " bits hi"}, capOut[63:32] & e.oeBits[63:32], e.outBits[63:32] & e.oeBits[63:32]);
        chk({e.req, " bits lo"}, capOut[31:0] & e.oeBits[31:0], e.outBits[31:0] & e.oeBits[31:0]);
        chk("R3 mdc period", periodBad, 0);
      end
      periodBad = 0;
    end
  end

  // PHY model: drives on MDC falling edge, answers only at PHY_ADDR
  always @(negedge mdc) begin
    int s;
    logic [4:0] a, r;
    logic rd;
    s  = riseCnt;
    a  = {capOut[36], capOut[37], capOut[38], capOut[39], capOut[40]};
    r  = {capOut[41], capOut[42], capOut[43], capOut[44], capOut[45]};
    rd = capOut[34] && !capOut[35];
    if (rd && a == PHY_ADDR && s == 47) mdioIn = 1'b0;
    else if (rd && a == PHY_ADDR && s >= 48) mdioIn = phyVal(r)[15-(s-48)];
    else mdioIn = 1'b1;
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic startCmd(input logic [31:0] cmd, input string req);
    expFrame_t e;
    logic rd;
    rd = (cmd[29:28] == 2'b10);
    for (int s = 0; s < 64; s++) begin
      e.outBits[s] = (s < 32) ? 1'b1 : cmd[31-(s-32)];
      e.oeBits[s]  = !(rd && s >= 46);
    end
    e.req = req;
    expQ.push_back(e);
    regWrite(2'd0, cmd);
  endtask

  task automatic waitDone(input string req);
    logic [31:0] v;
    int n = 0;
    do begin
      regRead(2'd2, v);
      n++;
    end while (!v[23] && n < 20000);
    chk({req, " event set"}, {31'd0, v[23]}, 32'd1);
  endtask

  function automatic logic [31:0] mkCmd(input logic [1:0] op, input logic [4:0] a,
                                        input logic [4:0] r, input logic [15:0] d);
    return {2'b01, op, a, r, 2'b10, d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, cmd, cmd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mdc", {31'd0, mdc}, 32'd0);
    chk("R1 oe", {31'd0, mdioOe}, 32'd0);
    chk("R1 out", {31'd0, mdioOut}, 32'd1);
    regRead(2'd0, v); chk("R1 cmd reg", v, 32'd0);
    regRead(2'd1, v); chk("R1 speed reg", v, 32'd0);
    regRead(2'd2, v); chk("R1 event reg", v, 32'd0);

    // R2 R10 R3 write frame at speed 2
    curSpeed = 2; regWrite(2'd1, 32'd2);
    cmd = mkCmd(2'b01, PHY_ADDR, 5'd4, 16'h1234);
    startCmd(cmd, "R2 R10 write frame");
    repeat (20) @(negedge clk);
    regRead(2'd2, v); chk("R6 event clear mid frame", v, 32'd0);
    waitDone("R6 write");
    regRead(2'd0, v); chk("R10 write keeps data reg", v, cmd);
    // R7 write-one-to-clear
    regWrite(2'd2, 32'h0000_0001);
    regRead(2'd2, v); chk("R7 zero bit keeps done", v, 32'h0080_0000);
    regWrite(2'd2, 32'h0080_0000);
    regRead(2'd2, v); chk("R7 one clears done", v, 32'd0);

    // R4 read from present PHY at speed 3
    curSpeed = 3; regWrite(2'd1, 32'd3);
    cmd = mkCmd(2'b10, PHY_ADDR, 5'd2, 16'h0000);
    startCmd(cmd, "R4 read frame");
    waitDone("R4 read");
    regRead(2'd0, v); chk("R4 read result", v, {cmd[31:16], phyVal(5'd2)});
    regWrite(2'd2, 32'h0080_0000);

    // R5 read from absent PHY
    cmd = mkCmd(2'b10, 5'd9, 5'd1, 16'h0000);
    startCmd(cmd, "R5 absent read frame");
    waitDone("R5 read");
    regRead(2'd0, v); chk("R5 no PHY gives FFFF", v[15:0], 32'h0000_FFFF);
    regWrite(2'd2, 32'h0080_0000);

    // R8 speed zero holds command
    regWrite(2'd1, 32'd0);
    cmd = mkCmd(2'b10, PHY_ADDR, 5'd7, 16'h0000);
    startCmd(cmd, "R8 held read frame");
    repeat (400) @(negedge clk);
    chk("R8 no mdc edge while stopped", riseCnt, 0);
    chk("R8 mdc low while stopped", {31'd0, mdc}, 32'd0);
    regRead(2'd2, v); chk("R8 no event while stopped", v, 32'd0);
    curSpeed = 3; regWrite(2'd1, 32'd3);
    waitDone("R8 released");
    regRead(2'd0, v); chk("R8 released read result", v, {cmd[31:16], phyVal(5'd7)});
    regWrite(2'd2, 32'h0080_0000);

    // R9 overrun during a read
    curSpeed = 2; regWrite(2'd1, 32'd2);
    cmd  = mkCmd(2'b10, PHY_ADDR, 5'd11, 16'h0000);
    cmd2 = mkCmd(2'b01, 5'd20, 5'd30, 16'hBEEF);
    startCmd(cmd, "R9 original read frame");
    repeat (60) @(negedge clk);
    regWrite(2'd0, cmd2);
    regRead(2'd2, v); chk("R9 overrun flag", v, 32'h0000_0001);
    regRead(2'd0, v); chk("R9 cmd reg unchanged", v, cmd);
    waitDone("R9 read");
    regRead(2'd0, v); chk("R9 result from first cmd", v, {cmd[31:16], phyVal(5'd11)});
    regWrite(2'd2, 32'h0080_0000);
    regRead(2'd2, v); chk("R9 overrun sticky", v, 32'h0000_0001);
    regWrite(2'd2, 32'h0000_0001);
    regRead(2'd2, v); chk("R9 overrun cleared", v, 32'd0);

    // R3 smallest speed
    curSpeed = 1; regWrite(2'd1, 32'd1);
    cmd = mkCmd(2'b10, PHY_ADDR, 5'd31, 16'h0000);
    startCmd(cmd, "R3 speed one frame");
    waitDone("R3 speed one");
    regRead(2'd0, v); chk("R3 speed one result", v, {cmd[31:16], phyVal(5'd31)});

    repeat (10) @(negedge clk);
    chk("R2 all frames seen", framesSeen, 6);
    chk("R9 no extra frame", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule